// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A small synchronous static RAM model whose data bus can be kept fully occupied. Reads and writes may be issued in any order on consecutive clocks with no idle cycle when the direction changes. Address and control are captured on the rising edge. Write data follows its address by two enabled cycles, which is the same lag that read data has. Because of this matching lag, every clock slot on the data buses belongs to exactly one operation.

An operation starts on a load cycle, when `adv_i` is low. It is a read, a write or a deselect. While `adv_i` is high, the previous operation continues as a four-beat burst driven by an internal counter. Each beat steps the low two address bits, in either linear or interleaved order. Each 18-bit word has two 9-bit lanes that can be written separately.

While `cke_ni` is high the whole pipeline holds its state. A read whose address matches a write still waiting for its data returns that data, merged lane by lane with the array contents.

Top module: `sram_nw`

## Requirements
- R1: After `rst_ni` is asserted, `rvalid_o` is low, the pipeline holds no operation, and the last operation is taken as a deselect, so that a burst beat issued before any load does nothing.
- R2: A read captured at enabled edge n drives `rdata_o` with `rvalid_o` high after enabled edge n+2. The result lasts until the next enabled edge.
- R3: For a write captured at enabled edge n, `wdata_i` is sampled at enabled edge n+2. Lane k, which is bits [9k+8:9k], is written only when `be_i[k]` was high at edge n.
- R4: A read returns every write captured before it, including a write captured on the immediately preceding edge whose data arrives in the same cycle as the read's array access. The data is merged lane by lane.
- R5: With `burst_il_i` low, beat c of a burst (c = 1..3, then wrapping mod 4) uses address bits [1:0] = base[1:0] + c mod 4. The upper bits come from the load address.
- R6: With `burst_il_i` high, beat c uses address bits [1:0] = base[1:0] XOR c.
- R7: A load cycle with `cs_i` low is a deselect. Two enabled cycles later `rvalid_o` is low, and no array word changes, even if `we_ni` is low. Burst beats that follow a deselect are also deselects.
- R8: While `cke_ni` is high, all synchronous inputs are ignored and all state and outputs hold. The two-cycle lags of R2 and R3 count only enabled edges.
- R9: On a burst beat (`adv_i` high), `cs_i`, `we_ni` and `addr_i` are ignored. The operation type stays the one chosen at the load. `be_i` is sampled on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high freezes everything |
| cs_i | input | 1 | Chip select on load cycles; low means deselect |
| adv_i | input | 1 | Low: load new operation; high: next burst beat |
| we_ni | input | 1 | Low: write, high: read (load cycles) |
| burst_il_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| be_i | input | 2 | Per-lane write enables |
| addr_i | input | 8 | Word address |
| wdata_i | input | 18 | Write data, two cycles after its address |
| rdata_o | output | 18 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
A wrong stage register or burst counter shows up on `rvalid_o` or `rdata_o` within two enabled cycles, because every read leaves the pipeline at a fixed slot. A write that has gone astray, for example to the wrong lane, wrong address or wrong cycle, stays hidden until that word is read back. For this reason the stimulus keeps addresses within a small window, so that read-backs come soon and often. A broken bypass path shows only when a read directly follows a write to the same word, and then it shows as a single bad lane on the next valid read.

// File: rtl/sram_nw_pkg.sv
package sram_nw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sram_nw_addr.sv
module sram_nw_addr
  import sram_nw_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 2
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          cs_i,
  input  logic          we_ni,
  input  logic          il_i,
  input  logic [AW-1:0] addr_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [BW-1:0] cnt_q, cnt_nx, off;
  op_e           op_q;

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    off    = il_i ? (base_q[BW-1:0] ^ cnt_nx) : (base_q[BW-1:0] + cnt_nx);
    if (load_i) begin
      op_o   = !cs_i ? OP_IDLE : (we_ni ? OP_RD : OP_WR);
      addr_o = addr_i;
    end else begin
      op_o   = op_q;
      addr_o = {base_q[AW-1:BW], off};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= OP_IDLE;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        op_q   <= op_o;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

  // burst beats keep the loaded operation type
  assert_burst_keeps_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> op_q == $past(op_q));

  assert_stall_holds_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(base_q) && $stable(cnt_q) && $stable(op_q));
endmodule

// File: rtl/sram_nw_array.sv
module sram_nw_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
)(
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [LANES-1:0] wbe_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    // read returns the old word on a same-address collision; bypass fixes it up
    always_ff @(posedge clk_i) begin
      if (en_i && we_i && wbe_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (en_i && re_i)             rd_q         <= mem[raddr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_nw_fwd.sv
module sram_nw_fwd #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int AW     = 8,
  localparam int DW    = LANES * LANE_W
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic [LANES-1:0] wbe_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    arr_rdata_i,
  input  logic             out_rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic [LANES-1:0] hit_q;
  logic [DW-1:0]    hdata_q;
  logic [DW-1:0]    merged;

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = hit_q[l] ? hdata_q[l*LANE_W +: LANE_W]
                                                 : arr_rdata_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q    <= '0;
      hdata_q  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else if (en_i) begin
      hit_q    <= (wr_i && rd_i && (waddr_i == raddr_i)) ? wbe_i : '0;
      hdata_q  <= wdata_i;
      rvalid_o <= out_rd_i;
      if (out_rd_i) rdata_o <= merged;
    end
  end

  assert_read_slot_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && out_rd_i |=> rvalid_o);

  assert_nonread_slot_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !out_rd_i |=> !rvalid_o);
endmodule

// File: rtl/sram_nw.sv
module sram_nw
  import sram_nw_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int DW     = LANES * LANE_W
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_ni,
  input  logic             cs_i,
  input  logic             adv_i,
  input  logic             we_ni,
  input  logic             burst_il_i,
  input  logic [LANES-1:0] be_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  typedef struct packed {
    op_e              op;
    logic [AW-1:0]    addr;
    logic [LANES-1:0] be;
  } stage_t;

  logic          en;
  op_e           nx_op;
  logic [AW-1:0] nx_addr;
  stage_t        s1_q, s2_q;
  logic [DW-1:0] arr_rdata;

  assign en = !cke_ni;

  sram_nw_addr #(.AW(AW), .BW(BURST_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (!adv_i),
    .cs_i   (cs_i),
    .we_ni  (we_ni),
    .il_i   (burst_il_i),
    .addr_i (addr_i),
    .op_o   (nx_op),
    .addr_o (nx_addr)
  );

  // s1: captured op (array read issued here); s2: data slot (write commit / output)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '{op: OP_IDLE, addr: '0, be: '0};
      s2_q <= '{op: OP_IDLE, addr: '0, be: '0};
    end else if (en) begin
      s1_q <= '{op: nx_op, addr: nx_addr, be: be_i};
      s2_q <= s1_q;
    end
  end

  sram_nw_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .en_i    (en),
    .we_i    (s2_q.op == OP_WR),
    .wbe_i   (s2_q.be),
    .waddr_i (s2_q.addr),
    .wdata_i (wdata_i),
    .re_i    (s1_q.op == OP_RD),
    .raddr_i (s1_q.addr),
    .rdata_o (arr_rdata)
  );

  sram_nw_fwd #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .wr_i        (s2_q.op == OP_WR),
    .rd_i        (s1_q.op == OP_RD),
    .waddr_i     (s2_q.addr),
    .raddr_i     (s1_q.addr),
    .wbe_i       (s2_q.be),
    .wdata_i     (wdata_i),
    .arr_rdata_i (arr_rdata),
    .out_rd_i    (s2_q.op == OP_RD),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  assert_freeze_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(rdata_o) && $stable(rvalid_o));

  assert_freeze_pipe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(s1_q) && $stable(s2_q));

  assert_pipe_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_ni |=> s2_q == $past(s1_q));
endmodule

// File: tb/sim_sram_nw.sv
module sim_sram_nw;
  localparam int DEPTH = 256;
  localparam int LW    = 9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cke_n = 1'b0, cs = 1'b0, adv = 1'b0, we_n = 1'b1, il = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [7:0]  addr = 8'h00;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rvalid;

  int total = 0, bad = 0;
  string phase = "R1";

  // reference model state
  logic [17:0] mem [DEPTH];
  int          q_op [2];
  logic [7:0]  q_a  [2];
  logic [1:0]  q_be [2];
  logic [7:0]  m_base;
  int          m_cnt, m_last, n_op;
  logic [7:0]  n_a;
  logic        e_valid;
  logic [17:0] e_data;

  always #10 clk = ~clk;

  sram_nw u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .cs_i(cs), .adv_i(adv),
    .we_ni(we_n), .burst_il_i(il), .be_i(be), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin q_op[i] = 0; q_a[i] = '0; q_be[i] = '0; end
    m_base = '0; m_cnt = 0; m_last = 0; e_valid = 1'b0; e_data = '0;
  endtask

  // one enabled edge: oldest op finishes, newest is decoded (0 idle, 1 read, 2 write)
  task automatic model_edge();
    if (cke_n) return;
    if (q_op[1] == 2)
      for (int l = 0; l < 2; l++)
        if (q_be[1][l]) mem[q_a[1]][l*LW +: LW] = wdata[l*LW +: LW];
    e_valid = (q_op[1] == 1);
    if (e_valid) e_data = mem[q_a[1]];
    if (!adv) begin
      n_op = !cs ? 0 : (we_n ? 1 : 2);
      m_base = addr; m_cnt = 0; m_last = n_op; n_a = addr;
    end else begin
      m_cnt = (m_cnt + 1) % 4;
      n_op = m_last;
      n_a = {m_base[7:2], il ? (m_base[1:0] ^ 2'(m_cnt)) : (m_base[1:0] + 2'(m_cnt))};
    end
    q_op[1] = q_op[0]; q_a[1] = q_a[0]; q_be[1] = q_be[0];
    q_op[0] = n_op;    q_a[0] = n_a;    q_be[0] = be;
  endtask

  task automatic cyc(input logic ck_n, input logic c, input logic ad, input logic w_n,
                     input logic [1:0] b, input logic [7:0] a, input logic [17:0] d);
    cke_n = ck_n; cs = c; adv = ad; we_n = w_n; be = b; addr = a; wdata = d;
    @(posedge clk); #1;
    model_edge();
    @(negedge clk);
    check(phase, "rvalid", 32'(rvalid), 32'(e_valid));
    if (e_valid) check(phase, "rdata", 32'(rdata), 32'(e_data));
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] b, input logic [17:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, b, a, d);
  endtask
  task automatic rd(input logic [7:0] a, input logic [17:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, a, d);
  endtask
  task automatic beat(input logic [1:0] b, input logic [17:0] d);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, b, 8'hff, d);
  endtask
  task automatic desel(input logic [17:0] d);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 8'h00, d);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "rvalid in reset", 32'(rvalid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: burst beats right after reset are deselects
    phase = "R1";
    beat(2'b11, 18'h3ffff);
    beat(2'b11, 18'h3ffff);
    beat(2'b11, 18'h3ffff);
    check("R1", "rvalid after reset beats", 32'(rvalid), 32'd0);

    // fill every word (R3)
    phase = "R3";
    for (int i = 0; i < DEPTH; i++) wr(8'(i), 2'b11, 18'(i * 7 + 3));
    desel(18'(DEPTH * 7 + 3 - 14));
    desel(18'(DEPTH * 7 + 3 - 7));
    for (int i = 0; i < 8; i++) rd(8'(i), 18'h0);
    desel('0); desel('0);

    // R4: bypass with lane merge
    phase = "R4";
    wr(8'h40, 2'b11, 18'h0);
    wr(8'h40, 2'b01, 18'h0);
    rd(8'h40, 18'h15555);
    rd(8'h40, 18'h3ffff);
    desel(18'h00000);
    check("R4", "merged read data", 32'(rdata), 32'({9'h0aa, 9'h1ff}));
    desel(18'h00000);
    check("R4", "second merged read", 32'(rdata), 32'({9'h0aa, 9'h1ff}));
    // alternating every cycle
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) wr(8'(8'h50 + (i % 4)), 2'(i % 3 + 1), 18'($urandom));
      else            rd(8'(8'h50 + ((i + 1) % 4)), 18'($urandom));
    end
    desel(18'($urandom)); desel(18'($urandom));

    // R3: lane-only writes
    phase = "R3";
    wr(8'h60, 2'b10, 18'h0);
    wr(8'h61, 2'b01, 18'h0);
    desel(18'h3fe00);
    desel(18'h001ff);
    rd(8'h60, 18'h0); rd(8'h61, 18'h0); desel('0); desel('0);

    // R5: linear bursts
    phase = "R5";
    il = 1'b0;
    wr(8'h21, 2'b11, 18'h0); beat(2'b11, 18'h0);
    beat(2'b11, 18'd100); beat(2'b11, 18'd101);
    desel(18'd102); desel(18'd103);
    rd(8'h22, 18'h0); beat(2'b00, 18'h0); beat(2'b00, 18'h0); beat(2'b00, 18'h0);
    beat(2'b00, 18'h0);
    desel('0); desel('0);

    // R6: interleaved bursts
    phase = "R6";
    il = 1'b1;
    wr(8'h31, 2'b11, 18'h0); beat(2'b11, 18'h0);
    beat(2'b11, 18'd200); beat(2'b11, 18'd201);
    desel(18'd202); desel(18'd203);
    rd(8'h33, 18'h0); beat(2'b00, 18'h0); beat(2'b00, 18'h0); beat(2'b00, 18'h0);
    desel('0); desel('0);
    il = 1'b0;

    // R7: deselect with we low writes nothing; beats stay idle
    phase = "R7";
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 8'h70, 18'h0);
    beat(2'b11, 18'h0);
    beat(2'b11, 18'h12345);
    check("R7", "rvalid on deselect slot", 32'(rvalid), 32'd0);
    beat(2'b11, 18'h2aaaa);
    rd(8'h70, 18'h0); rd(8'h71, 18'h0); desel('0); desel('0);

    // R9: cs/we/addr ignored on beats
    phase = "R9";
    rd(8'h44, 18'h0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 8'h99, 18'h0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h10, 18'h0);
    desel('0); desel('0); desel('0);

    // R8: stalls between address and data
    phase = "R8";
    wr(8'h80, 2'b11, 18'h0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 8'h33, 18'h3ffff);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 8'h33, 18'h3ffff);
    rd(8'h80, 18'h0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 8'h80, 18'h3ffff);
    desel(18'h0abcd);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 8'h80, 18'h11111);
    desel('0);
    check("R8", "read after stalled write", 32'(rdata), 32'h0abcd);
    desel('0);

    // R2 and mixed traffic with stalls and bursts
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) il = ~il;
      cyc(($urandom % 8) == 0, ($urandom % 6) != 0, ($urandom % 3) == 0, 1'($urandom),
          2'($urandom), 8'($urandom % 16), 18'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule